// File: doc/BRIEF.md
# Preset Timer Busy/Done Control

This block is the control section of a preset timer or preset counter. A host bus drives a station select, a 5-bit function code, a 4-bit subaddress and two strobes (a first strobe, then a second strobe). The block decodes these into actions on the counter and the prescaler: load, clear, divider write, preset-out pulse and read hold. It also tests and changes its own flags. The counter and the prescaler are separate blocks, and this one only produces their control strobes.

The block holds a Busy flag, which gates counting and is also driven out as a gate signal. It holds a Done flag, an interrupt-enable flag, a clear-inhibit flag and a pending-restart flag. The interrupt request follows Done, but only while interrupts are enabled and the bus is not busy. The Q response reports either the interrupt state or Busy, depending on the tested function. Front-panel pulses can start, restart or stop a cycle. The counter's End signal closes a cycle. If End is fed back into Restart, the block runs as a free-running clock generator: each new cycle begins on the next prescaled count tick.

Every input is sampled on one clock. Strobes and front-panel pulses are one cycle wide.

Top module: `bdTimerCtrl`

## Requirements
- R1: Bus functions act only when `modSel` is 1 and `subAddr` is 0. Any other command changes no flag, drives no counter or divider strobe and gives `qResp` = 0.
- R2: Function 26 with `strobe1` sets interrupt-enable. Function 24 with `strobe1` clears it.
- R3: A `startPulse` sets Busy without clearing the counter. Function 28 with `strobe1` drives `cntClear` in that cycle and sets Busy at the next edge.
- R4: `endIn` while Busy is 1 clears Busy. It also sets Done, unless the clear-inhibit flag is set. `endIn` while Busy is 0 has no effect.
- R5: Function 10 with `strobe2`, while interrupt-enable is 1, clears Done and sets clear-inhibit. Clear-inhibit stays set until the next cycle start. The same command has no effect while interrupt-enable is 0.
- R6: `irqL` = Done AND interrupt-enable AND NOT `busB`.
- R7: `qResp` = Done AND interrupt-enable for functions 8 and 10. It equals Busy for function 27, and it is 0 for every other function.
- R8: Every cycle start clears Done. A cycle start is a start pulse, function 28, or a restart that fires.
- R9: `restartPulse` sets a pending flag. While the flag is pending, Busy is 0 and `inTick` is 1, the block sets Busy at the next edge and drives `cntClear` in that same cycle. The pending flag clears one edge after Busy is 1.
- R10: `stopPulse` clears Busy, leaves Done unchanged, and takes priority over any start.
- R11: `initZ` with `strobe2` forms Initialize. Initialize drives `cntClear` and `divClear` in that cycle and clears all flags at the edge, including interrupt-enable.
- R12: Function 16 drives `divWrite` during `strobe1`, drives `presetOut` during `strobe2`, and holds `cntLoad` from the cycle after `strobe1` through the `strobe2` cycle.
- R13: Function 0 holds `readHold` at 1 for as long as the command is presented.
- R14: While `rstN` is low, all flags are 0, and `irqL`, `qResp` and `busyGate` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modSel | input | 1 | Station select for bus commands |
| fnCode | input | 5 | Function code |
| subAddr | input | 4 | Subaddress |
| strobe1 | input | 1 | First bus strobe, one cycle |
| strobe2 | input | 1 | Second bus strobe, one cycle |
| initZ | input | 1 | Broadcast initialize, qualified by strobe2 |
| busB | input | 1 | Bus busy; masks the interrupt request |
| startPulse | input | 1 | Front-panel start |
| restartPulse | input | 1 | Front-panel restart |
| stopPulse | input | 1 | Front-panel stop |
| endIn | input | 1 | Counter passed through zero |
| inTick | input | 1 | Prescaled count tick |
| irqL | output | 1 | Interrupt request |
| qResp | output | 1 | Q response |
| cntLoad | output | 1 | Counter load enable |
| cntClear | output | 1 | Counter clear |
| divWrite | output | 1 | Divider ratio register write |
| divClear | output | 1 | Divider ratio register clear |
| presetOut | output | 1 | Preset-out pulse |
| readHold | output | 1 | Freeze counter for readout |
| busyGate | output | 1 | Busy flag as a gate |

## Verification
The state that can go wrong here is the flags. Busy appears directly on `busyGate` one edge after the event that should change it, so an error there shows up immediately. Done and interrupt-enable are only visible through `irqL` and through the Q response of functions 8 and 10. A Done that was wrongly cleared or wrongly kept therefore surfaces at the next L test, or as soon as enable is set again. Clear-inhibit and the pending-restart flag are hidden until the next End or the next tick: a bad inhibit shows as a missing or extra Done at the end of the following cycle, and a bad pending flag shows as a Busy that rises on the wrong tick.

// File: rtl/bdTimerPkg.sv
package bdTimerPkg;

  localparam int FN_W = 5;
  localparam int SA_W = 4;

  typedef struct packed {
    logic rdCnt;       // read hold level
    logic testL;       // L test (Q source)
    logic clrL;        // clear L at second strobe
    logic enL;         // enable L at first strobe
    logic disL;        // disable L at first strobe
    logic testBusy;    // Busy test (Q source)
    logic startZero;   // clear counter and start
    logic loadCnt;     // counter load window
    logic wrDiv;       // divider write
    logic presetPulse; // preset-out pulse
    logic init;        // Initialize
  } cmdStrobes_t;

endpackage

// File: rtl/bdCmdDecode.sv
module bdCmdDecode
  import bdTimerPkg::*;
#(
  parameter int FN_READ  = 0,
  parameter int FN_TSTA  = 8,
  parameter int FN_CLRL  = 10,
  parameter int FN_LOAD  = 16,
  parameter int FN_DISL  = 24,
  parameter int FN_ENL   = 26,
  parameter int FN_TBSY  = 27,
  parameter int FN_SZERO = 28
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modSel,
  input  logic [FN_W-1:0] fnCode,
  input  logic [SA_W-1:0] subAddr,
  input  logic            strobe1,
  input  logic            strobe2,
  input  logic            initZ,
  output cmdStrobes_t     cmd
);

  logic addressed;
  logic dataPhase;
  logic isRead, isTestA, isClrL, isLoad, isDisL, isEnL, isTBusy, isSZero;

  assign addressed = modSel && (subAddr == '0);

  assign isRead  = addressed && (fnCode == FN_W'(FN_READ));
  assign isTestA = addressed && (fnCode == FN_W'(FN_TSTA));
  assign isClrL  = addressed && (fnCode == FN_W'(FN_CLRL));
  assign isLoad  = addressed && (fnCode == FN_W'(FN_LOAD));
  assign isDisL  = addressed && (fnCode == FN_W'(FN_DISL));
  assign isEnL   = addressed && (fnCode == FN_W'(FN_ENL));
  assign isTBusy = addressed && (fnCode == FN_W'(FN_TBSY));
  assign isSZero = addressed && (fnCode == FN_W'(FN_SZERO));

  // window from the edge after the first strobe through the second strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   dataPhase <= 1'b0;
    else if (initZ && strobe2)   dataPhase <= 1'b0;
    else if (strobe1)            dataPhase <= 1'b1;
    else if (strobe2)            dataPhase <= 1'b0;
  end

  always_comb begin
    cmd             = '0;
    cmd.rdCnt       = isRead;
    cmd.testL       = isTestA || isClrL;
    cmd.clrL        = isClrL && strobe2;
    cmd.enL         = isEnL && strobe1;
    cmd.disL        = isDisL && strobe1;
    cmd.testBusy    = isTBusy;
    cmd.startZero   = isSZero && strobe1;
    cmd.loadCnt     = isLoad && dataPhase;
    cmd.wrDiv       = isLoad && strobe1;
    cmd.presetPulse = isLoad && strobe2;
    cmd.init        = initZ && strobe2;
  end

endmodule

// File: rtl/bdFlagCtrl.sv
module bdFlagCtrl
  import bdTimerPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  cmdStrobes_t cmd,
  input  logic        busB,
  input  logic        startPulse,
  input  logic        restartPulse,
  input  logic        stopPulse,
  input  logic        endIn,
  input  logic        inTick,
  output logic        busy,
  output logic        irqL,
  output logic        qResp,
  output logic        restartFire
);

  logic done, irqEn, clrInhibit, restartPend;
  logic cycleStart, endEvent, clearL;

  assign restartFire = restartPend && inTick && !busy && !cmd.init;
  assign cycleStart  = startPulse || cmd.startZero || restartFire;
  assign endEvent    = endIn && busy;
  assign clearL      = cmd.clrL && irqEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               busy <= 1'b0;
    else if (cmd.init)       busy <= 1'b0;
    else if (stopPulse)      busy <= 1'b0;
    else if (endEvent)       busy <= 1'b0;
    else if (cycleStart)     busy <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          done <= 1'b0;
    else if (cmd.init)                  done <= 1'b0;
    else if (endEvent && !clrInhibit)   done <= 1'b1;
    else if (cycleStart || clearL)      done <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               irqEn <= 1'b0;
    else if (cmd.init)       irqEn <= 1'b0;
    else if (cmd.disL)       irqEn <= 1'b0;
    else if (cmd.enL)        irqEn <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               clrInhibit <= 1'b0;
    else if (cmd.init)       clrInhibit <= 1'b0;
    else if (cycleStart)     clrInhibit <= 1'b0;
    else if (clearL)         clrInhibit <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               restartPend <= 1'b0;
    else if (cmd.init)       restartPend <= 1'b0;
    else if (restartPulse)   restartPend <= 1'b1;
    else if (busy)           restartPend <= 1'b0;
  end

  assign irqL = done && irqEn && !busB;

  always_comb begin
    if (cmd.testL)          qResp = done && irqEn;
    else if (cmd.testBusy)  qResp = busy;
    else                    qResp = 1'b0;
  end

endmodule

// File: rtl/bdTimerCtrl.sv
module bdTimerCtrl
  import bdTimerPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            modSel,
  input  logic [FN_W-1:0] fnCode,
  input  logic [SA_W-1:0] subAddr,
  input  logic            strobe1,
  input  logic            strobe2,
  input  logic            initZ,
  input  logic            busB,
  input  logic            startPulse,
  input  logic            restartPulse,
  input  logic            stopPulse,
  input  logic            endIn,
  input  logic            inTick,
  output logic            irqL,
  output logic            qResp,
  output logic            cntLoad,
  output logic            cntClear,
  output logic            divWrite,
  output logic            divClear,
  output logic            presetOut,
  output logic            readHold,
  output logic            busyGate
);

  cmdStrobes_t cmd;
  logic restartFire;

  bdCmdDecode uDecode (
    .clk     (clk),
    .rstN    (rstN),
    .modSel  (modSel),
    .fnCode  (fnCode),
    .subAddr (subAddr),
    .strobe1 (strobe1),
    .strobe2 (strobe2),
    .initZ   (initZ),
    .cmd     (cmd)
  );

  bdFlagCtrl uFlags (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .busB         (busB),
    .startPulse   (startPulse),
    .restartPulse (restartPulse),
    .stopPulse    (stopPulse),
    .endIn        (endIn),
    .inTick       (inTick),
    .busy         (busyGate),
    .irqL         (irqL),
    .qResp        (qResp),
    .restartFire  (restartFire)
  );

  assign cntLoad   = cmd.loadCnt;
  assign cntClear  = cmd.startZero || restartFire || cmd.init;
  assign divWrite  = cmd.wrDiv;
  assign divClear  = cmd.init;
  assign presetOut = cmd.presetPulse;
  assign readHold  = cmd.rdCnt;

endmodule

// File: rtl/bdTimerCtrlChk.sv
module bdTimerCtrlChk
  import bdTimerPkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            modSel,
  input logic [FN_W-1:0] fnCode,
  input logic [SA_W-1:0] subAddr,
  input logic            strobe1,
  input logic            strobe2,
  input logic            initZ,
  input logic            busB,
  input logic            startPulse,
  input logic            restartPulse,
  input logic            stopPulse,
  input logic            endIn,
  input logic            inTick,
  input logic            irqL,
  input logic            qResp,
  input logic            cntLoad,
  input logic            cntClear,
  input logic            divWrite,
  input logic            divClear,
  input logic            presetOut,
  input logic            readHold,
  input logic            busyGate
);

  // R6
  irq_bus_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqL |-> !busB);

  // R1
  q_subaddr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (subAddr != '0 || !modSel) |-> !qResp);

  // R4
  end_clears_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (endIn && busyGate) |=> !busyGate);

  // R10
  stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |=> !busyGate);

  // R11
  init_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (initZ && strobe2) |=> (!busyGate && !irqL));

  // R12
  div_write_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    divWrite |-> (strobe1 && modSel));

  // R12
  preset_out_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    presetOut |-> (strobe2 && cntLoad));

endmodule

bind bdTimerCtrl bdTimerCtrlChk uChk (.*);

// File: tb/bdTimerCtrl_test.sv
module bdTimerCtrl_test;
  import bdTimerPkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modSel = 1'b0;
  logic [FN_W-1:0] fnCode = '0;
  logic [SA_W-1:0] subAddr = '0;
  logic strobe1 = 1'b0, strobe2 = 1'b0, initZ = 1'b0, busB = 1'b0;
  logic startPulse = 1'b0, restartPulse = 1'b0, stopPulse = 1'b0;
  logic endIn = 1'b0, inTick = 1'b0;
  logic irqL, qResp, cntLoad, cntClear, divWrite, divClear, presetOut, readHold, busyGate;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  bdTimerCtrl uut (.*);

  typedef struct packed {
    logic       sel;
    logic [4:0] fn;
    logic [3:0] sa;
    logic s1, s2, st, rs, sp, en, tk, b;
    logic eBusy, eDone, eL, eQ;
  } step_t;

  localparam logic T = 1'b1;
  localparam logic F = 1'b0;
  localparam int NS = 35;

  // fields: sel fn sa s1 s2 start restart stop end tick B | busy doneVis L Q
  // eDone is checked through L/Q only; it documents the intended flag.
  localparam step_t STEPS [NS] = '{
    '{T,5'd26,4'd0,T,F,F,F,F,F,F,F, F,F,F,F}, // 1  R2 enable L
    '{T,5'd8 ,4'd0,F,F,F,F,F,F,F,F, F,F,F,F}, // 2  R7 test L, nothing done
    '{T,5'd0 ,4'd0,F,F,T,F,F,F,F,F, T,F,F,F}, // 3  R3 start pulse
    '{T,5'd27,4'd0,F,F,F,F,F,F,F,F, T,F,F,T}, // 4  R7 test busy
    '{T,5'd8 ,4'd0,F,F,F,F,F,T,F,F, F,T,T,T}, // 5  R4 end sets done
    '{T,5'd27,4'd0,F,F,F,F,F,F,F,F, F,T,T,F}, // 6  R7 busy test low
    '{T,5'd8 ,4'd1,F,F,F,F,F,F,F,F, F,T,T,F}, // 7  R1 wrong subaddress
    '{T,5'd10,4'd0,F,T,F,F,F,F,F,F, F,F,F,F}, // 8  R5 clear L
    '{T,5'd0 ,4'd0,F,F,F,F,F,T,F,F, F,F,F,F}, // 9  R4 end while idle
    '{T,5'd28,4'd0,T,F,F,F,F,F,F,F, T,F,F,F}, // 10 R3 start at zero
    '{T,5'd0 ,4'd0,F,F,F,F,F,T,F,F, F,T,T,F}, // 11 R4
    '{T,5'd10,4'd0,F,T,F,F,F,F,F,F, F,F,F,F}, // 12 R5
    '{T,5'd0 ,4'd0,F,F,F,T,F,F,F,F, F,F,F,F}, // 13 R9 restart pending
    '{T,5'd0 ,4'd0,F,F,F,F,F,F,T,F, T,F,F,F}, // 14 R9 fires on tick
    '{T,5'd24,4'd0,T,F,F,F,F,F,F,F, T,F,F,F}, // 15 R2 disable L
    '{T,5'd8 ,4'd0,F,F,F,F,F,T,F,F, F,T,F,F}, // 16 R6 done masked by enable
    '{T,5'd10,4'd0,F,T,F,F,F,F,F,F, F,T,F,F}, // 17 R5 clear ignored when disabled
    '{T,5'd26,4'd0,T,F,F,F,F,F,F,F, F,T,T,F}, // 18 R5 done survived
    '{T,5'd0 ,4'd0,F,F,T,F,F,F,F,F, T,F,F,F}, // 19 R8 start clears done
    '{T,5'd0 ,4'd0,F,F,F,F,T,F,F,F, F,F,F,F}, // 20 R10 stop, no done
    '{T,5'd0 ,4'd0,F,F,T,F,F,F,F,F, T,F,F,F}, // 21
    '{T,5'd0 ,4'd0,F,F,F,F,F,T,F,T, F,T,F,F}, // 22 R6 B masks L
    '{T,5'd0 ,4'd0,F,F,F,F,F,F,F,F, F,T,T,F}, // 23 R6 L returns
    '{T,5'd0 ,4'd0,F,F,T,F,F,F,F,F, T,F,F,F}, // 24 R8
    '{T,5'd10,4'd0,F,T,F,F,F,F,F,F, T,F,F,F}, // 25 R5 inhibit while busy
    '{T,5'd0 ,4'd0,F,F,F,F,F,T,F,F, F,F,F,F}, // 26 R5 end inhibited
    '{T,5'd0 ,4'd0,F,F,T,F,F,F,F,F, T,F,F,F}, // 27 R5 start releases inhibit
    '{T,5'd0 ,4'd0,F,F,F,F,F,T,F,F, F,T,T,F}, // 28 R4
    '{T,5'd0 ,4'd0,F,F,T,F,F,F,F,F, T,F,F,F}, // 29
    '{T,5'd0 ,4'd0,F,F,F,T,F,T,F,F, F,T,T,F}, // 30 R9 end fed to restart
    '{T,5'd0 ,4'd0,F,F,F,F,F,F,T,F, T,F,F,F}, // 31 R9 R8 new cycle
    '{T,5'd0 ,4'd0,F,F,F,F,F,F,T,F, T,F,F,F}, // 32 R9
    '{F,5'd27,4'd0,F,F,F,F,F,F,F,F, T,F,F,F}, // 33 R1 not selected
    '{T,5'd0 ,4'd0,F,F,F,F,F,T,F,F, F,T,T,F}, // 34 R4
    '{T,5'd0 ,4'd0,F,F,F,F,F,F,T,F, F,T,T,F}  // 35 R9 pending gone
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    modSel = 1'b1; fnCode = '0; subAddr = '0;
    strobe1 = 0; strobe2 = 0; initZ = 0; busB = 0;
    startPulse = 0; restartPulse = 0; stopPulse = 0; endIn = 0; inTick = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    // R14 reset state
    #12;
    chk("R14 busyGate", busyGate, 1'b0);
    chk("R14 irqL", irqL, 1'b0);
    chk("R14 qResp", qResp, 1'b0);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NS; i++) begin
      @(negedge clk);
      modSel = STEPS[i].sel; fnCode = STEPS[i].fn; subAddr = STEPS[i].sa;
      strobe1 = STEPS[i].s1; strobe2 = STEPS[i].s2;
      startPulse = STEPS[i].st; restartPulse = STEPS[i].rs; stopPulse = STEPS[i].sp;
      endIn = STEPS[i].en; inTick = STEPS[i].tk; busB = STEPS[i].b;
      cyc();
      chk($sformatf("table row %0d busy", i + 1), busyGate, STEPS[i].eBusy);
      chk($sformatf("table row %0d L", i + 1), irqL, STEPS[i].eL);
      chk($sformatf("table row %0d Q", i + 1), qResp, STEPS[i].eQ);
    end

    // R12 load/divider/preset sequence
    @(negedge clk); idle(); fnCode = 5'd16; strobe1 = 1; #1;
    chk("R12 divWrite at strobe1", divWrite, 1'b1);
    chk("R12 no load at strobe1", cntLoad, 1'b0);
    @(negedge clk); strobe1 = 0; #1;
    chk("R12 load window", cntLoad, 1'b1);
    chk("R12 no divWrite", divWrite, 1'b0);
    @(negedge clk); strobe2 = 1; #1;
    chk("R12 presetOut", presetOut, 1'b1);
    chk("R12 load through strobe2", cntLoad, 1'b1);
    @(negedge clk); strobe2 = 0; #1;
    chk("R12 load closed", cntLoad, 1'b0);
    // R1 wrong subaddress drives no strobe
    @(negedge clk); subAddr = 4'd3; strobe1 = 1; #1;
    chk("R1 divWrite ignored", divWrite, 1'b0);
    @(negedge clk); strobe1 = 0; strobe2 = 1; #1;
    chk("R1 presetOut ignored", presetOut, 1'b0);
    // R13 read hold
    @(negedge clk); idle(); fnCode = 5'd0; #1;
    chk("R13 readHold", readHold, 1'b1);
    @(negedge clk); subAddr = 4'd1; #1;
    chk("R13 readHold other subaddress", readHold, 1'b0);
    // R3 start at zero clears counter
    @(negedge clk); idle(); fnCode = 5'd28; strobe1 = 1; #1;
    chk("R3 cntClear", cntClear, 1'b1);
    cyc();
    chk("R3 busy after start at zero", busyGate, 1'b1);
    @(negedge clk); idle(); strobe2 = 1; // close data phase
    @(negedge clk); idle(); startPulse = 1; #1;
    chk("R3 start pulse keeps counter", cntClear, 1'b0);
    // R9 restart clears counter on the firing tick
    @(negedge clk); idle(); stopPulse = 1;
    @(negedge clk); idle(); restartPulse = 1;
    @(negedge clk); idle(); #1;
    chk("R9 no clear without tick", cntClear, 1'b0);
    @(negedge clk); inTick = 1; #1;
    chk("R9 clear on tick", cntClear, 1'b1);
    cyc();
    chk("R9 busy on tick", busyGate, 1'b1);
    // R11 initialize
    @(negedge clk); idle(); endIn = 1;
    cyc();
    chk("R11 L before init", irqL, 1'b1);
    @(negedge clk); idle(); initZ = 1; strobe2 = 1; #1;
    chk("R11 cntClear", cntClear, 1'b1);
    chk("R11 divClear", divClear, 1'b1);
    cyc();
    chk("R11 L cleared", irqL, 1'b0);
    @(negedge clk); idle(); startPulse = 1;
    @(negedge clk); idle(); endIn = 1;
    cyc();
    chk("R11 enable cleared", irqL, 1'b0);
    @(negedge clk); idle(); fnCode = 5'd26; strobe1 = 1;
    cyc();
    chk("R11 done still set", irqL, 1'b1);
    @(negedge clk); idle();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule